// File: doc/BRIEF.md
# Per-Class Bandwidth Deficit Counter

This block sits at a switch output port and keeps one signed deficit counter for each service level. A counter measures how far a class's consumed bandwidth runs ahead of the bandwidth reserved for it. Each time the class moves one 64-byte unit toward the output, a one-cycle strobe adds one to its counter. A per-class leak timer subtracts one each time a programmed number of cycles elapses. The programmed interval is therefore the reserved rate. For example, one unit every 50 cycles at 100 MHz reserves 128 MB/s.

All counter values are output side by side for the scheduler, which serves the classes with the lowest deficit first. Each class also gets a flag that compares its counter against a shared signed threshold. The congestion detector uses this flag to tell whether a class is oversubscribing. A threshold of 64 units corresponds to 4 KB. The counters saturate instead of wrapping. An interval of zero turns the leak off for that class.

Top module: `bw_deficit_bank`

## Requirements
- R1: After a synchronous active-low reset, every deficit counter and every leak cycle counter is zero.
- R2: A strobe on `unit_sent[k]` with no leak on class k in that cycle raises class k's deficit by exactly one at the next clock edge. Other classes are not affected by it.
- R3: A deficit at +127 does not wrap. A further increment with no leak leaves it at +127.
- R4: A deficit at -128 does not wrap. A further leak with no increment leaves it at -128.
- R5: With interval N > 0, class k's cycle counter counts up from zero. A leak happens at the clock edge that ends the N-th cycle, which lowers the deficit by one and restarts the count at zero.
- R6: An interval of zero disables the leak for that class and holds its cycle counter at zero.
- R7: An increment and a leak in the same cycle cancel, and the deficit keeps its value.
- R8: `over_limit[k]` is 1 exactly when class k's deficit, read as two's complement, is strictly greater than the signed `limit_thresh`.
- R9: If the interval is lowered to N while the cycle counter already holds N-1 or more, the leak happens at the next clock edge and the count restarts.
- R10: Class k's deficit is presented on `deficit_flat[k*8 +: 8]` (default widths), and its interval is read from `leak_interval_flat[k*8 +: 8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unit_sent | input | NUM_CLASS | One-cycle strobe per class, one 64-byte unit sent |
| leak_interval_flat | input | NUM_CLASS*IVL_W | Per-class leak interval in cycles, 0 disables the leak |
| limit_thresh | input | CNT_W | Signed over-allowance threshold, shared by all classes |
| deficit_flat | output | NUM_CLASS*CNT_W | Per-class signed deficit values |
| over_limit | output | NUM_CLASS | Per-class flag, deficit greater than threshold |

## Verification
The assertions assume that the strobe and interval inputs are valid from the first clock edge after reset is released. The step-size check in particular assumes that no input is X while reset is low. The stimulus drives every input to a defined value before reset is released. It changes inputs only just after a rising edge. Intervals are kept small, so that leaks happen often and both saturation rails are reached within a short run. Intervals are also changed in the middle of a count, including to values below the elapsed count.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
    // Net action applied to one deficit counter in a cycle.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;
endpackage

// File: rtl/bwd_leak_timer.sv
// bwd_leak_timer: per-class cycle counter that fires a one-cycle leak pulse
// each time the programmed interval elapses.
// Assumes: interval is a plain cycle count; 0 disables the leak and parks
// the counter at zero. Lowering the interval below the elapsed count fires
// the pulse on the next edge.
module bwd_leak_timer #(
    parameter int IVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IVL_W-1:0] interval,
    output logic             leak
);
    logic [IVL_W-1:0] elapsed;

    // Leak when the count has reached the last cycle of the interval.
    assign leak = (interval != '0) && (elapsed >= interval - IVL_W'(1));

    // Advance, restart on leak, or park while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (interval == '0 || leak) begin
            elapsed <= '0;
        end else begin
            elapsed <= elapsed + IVL_W'(1);
        end
    end

    assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (interval == '0) |=> (elapsed == '0));

    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        leak |=> (elapsed == '0));

    assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (interval != '0 && !leak) |=> (elapsed == $past(elapsed) + IVL_W'(1)));
endmodule

// File: rtl/bwd_deficit_cell.sv
// bwd_deficit_cell: one signed saturating deficit counter.
// Assumes: up and down are single-cycle events; both together cancel.
module bwd_deficit_cell
    import bwd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    up,
    input  logic                    down,
    output logic signed [CNT_W-1:0] value
);
    localparam logic signed [CNT_W-1:0] MAX_V = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic signed [CNT_W-1:0] MIN_V = {1'b1, {(CNT_W-1){1'b0}}};

    step_e step;

    // Pick the net step, blocking it at either rail.
    always_comb begin
        step = STEP_HOLD;
        if (up && !down && value != MAX_V) begin
            step = STEP_UP;
        end else if (down && !up && value != MIN_V) begin
            step = STEP_DOWN;
        end
    end

    // Apply the chosen step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else begin
            case (step)
                STEP_UP:   value <= value + CNT_W'(1);
                STEP_DOWN: value <= value - CNT_W'(1);
                default:   value <= value;
            endcase
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (value == MAX_V && up && !down) |=> (value == MAX_V));

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (value == MIN_V && down && !up) |=> (value == MIN_V));

    assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (up && down) |=> $stable(value));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (value == $past(value)) || (value == $past(value) + CNT_W'(1))
        || (value == $past(value) - CNT_W'(1)));
endmodule

// File: rtl/bw_deficit_bank.sv
// bw_deficit_bank: one deficit counter and leak timer per service level,
// plus a signed over-threshold flag per class.
// Assumes: unit_sent carries at most one unit per class per cycle.
module bw_deficit_bank #(
    parameter int NUM_CLASS = 4,
    parameter int CNT_W     = 8,
    parameter int IVL_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CLASS-1:0]       unit_sent,
    input  logic [NUM_CLASS*IVL_W-1:0] leak_interval_flat,
    input  logic [CNT_W-1:0]           limit_thresh,
    output logic [NUM_CLASS*CNT_W-1:0] deficit_flat,
    output logic [NUM_CLASS-1:0]       over_limit
);
    localparam int TOTAL_CNT_BITS = NUM_CLASS * CNT_W;

    logic [NUM_CLASS-1:0]       leak_pulse;
    logic [TOTAL_CNT_BITS-1:0]  cnt_bus;

    for (genvar k = 0; k < NUM_CLASS; k++) begin : g_class
        logic signed [CNT_W-1:0] cls_value;

        bwd_leak_timer #(.IVL_W(IVL_W)) i_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .interval (leak_interval_flat[k*IVL_W +: IVL_W]),
            .leak     (leak_pulse[k])
        );

        bwd_deficit_cell #(.CNT_W(CNT_W)) i_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .up    (unit_sent[k]),
            .down  (leak_pulse[k]),
            .value (cls_value)
        );

        assign cnt_bus[k*CNT_W +: CNT_W] = cls_value;
        // Signed compare of the class deficit against the shared threshold.
        assign over_limit[k] = cls_value > $signed(limit_thresh);
    end

    assign deficit_flat = cnt_bus;
endmodule

// File: tb/test_bw_deficit_bank.sv
module test_bw_deficit_bank;
    localparam int NC = 4;
    localparam int CW = 8;
    localparam int IW = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NC-1:0]    unit_sent = '0;
    logic [NC*IW-1:0] leak_interval_flat = '0;
    logic [CW-1:0]    limit_thresh = 8'd64;
    logic [NC*CW-1:0] deficit_flat;
    logic [NC-1:0]    over_limit;

    int vectors = 0;
    int errors = 0;
    int m_val [NC];
    int m_cnt [NC];
    bit finished = 0;

    always #5 clk = ~clk;

    bw_deficit_bank #(.NUM_CLASS(NC), .CNT_W(CW), .IVL_W(IW)) i_bw_deficit_bank (
        .clk(clk), .rst_n(rst_n), .unit_sent(unit_sent),
        .leak_interval_flat(leak_interval_flat), .limit_thresh(limit_thresh),
        .deficit_flat(deficit_flat), .over_limit(over_limit)
    );

    function automatic bit model_leak(int cnt, int iv);
        return (iv != 0) && (cnt >= iv - 1);
    endfunction

    function automatic int model_cnt(int cnt, int iv);
        if (iv == 0 || model_leak(cnt, iv)) return 0;
        return cnt + 1;
    endfunction

    function automatic int model_val(int v, bit up, bit dn);
        if (up && !dn && v < 127) return v + 1;
        if (dn && !up && v > -128) return v - 1;
        return v;
    endfunction

    function automatic int sx(logic [CW-1:0] x);
        return int'($signed(x));
    endfunction

    task automatic check_all(string tag);
        for (int k = 0; k < NC; k++) begin
            int got = sx(deficit_flat[k*CW +: CW]);
            bit exp_over = m_val[k] > sx(limit_thresh);
            vectors++;
            if (got != m_val[k]) begin
                errors++;
                $display("FAIL %s class %0d deficit: actual %0d expected %0d", tag, k, got, m_val[k]);
            end
            vectors++;
            if (over_limit[k] != exp_over) begin
                errors++;
                $display("FAIL %s R8 class %0d over_limit: actual %0b expected %0b", tag, k, over_limit[k], exp_over);
            end
        end
    endtask

    // One clock: predict from current inputs, then compare after the edge.
    task automatic cycle(string tag);
        int nv [NC];
        int nc [NC];
        for (int k = 0; k < NC; k++) begin
            int iv = int'(leak_interval_flat[k*IW +: IW]);
            nv[k] = model_val(m_val[k], unit_sent[k], model_leak(m_cnt[k], iv));
            nc[k] = model_cnt(m_cnt[k], iv);
        end
        @(posedge clk);
        #1;
        for (int k = 0; k < NC; k++) begin
            m_val[k] = nv[k];
            m_cnt[k] = nc[k];
        end
        check_all(tag);
    endtask

    task automatic set_iv(int k, int v);
        leak_interval_flat[k*IW +: IW] = IW'(v);
    endtask

    initial begin
        for (int k = 0; k < NC; k++) begin
            m_val[k] = 0;
            m_cnt[k] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check_all("R1");

        // Class 0 climbs to the upper rail, no leaks anywhere.
        unit_sent = 4'b0001;
        for (int i = 0; i < 140; i++) cycle("R2,R3,R6,R10");

        // Class 1 leaks every cycle down to the lower rail.
        unit_sent = '0;
        set_iv(1, 1);
        for (int i = 0; i < 140; i++) cycle("R4,R5");

        // Class 2 sends every cycle while leaking every 3 cycles: cancels.
        unit_sent = 4'b0100;
        set_iv(2, 3);
        set_iv(3, 5);
        for (int i = 0; i < 30; i++) cycle("R7,R5");

        // Class 3: long interval, then lowered below the elapsed count.
        unit_sent = '0;
        set_iv(3, 200);
        for (int i = 0; i < 20; i++) cycle("R5");
        set_iv(3, 4);
        cycle("R9");
        for (int i = 0; i < 10; i++) cycle("R9,R5");

        // Threshold corner: equal vs one below the deficit.
        limit_thresh = CW'(m_val[0]);
        cycle("R8");
        limit_thresh = CW'(m_val[0] - 1);
        cycle("R8");

        // Constrained random phase with a fixed seed.
        void'($urandom(32'h5eed_1234));
        for (int k = 0; k < NC; k++) set_iv(k, $urandom_range(0, 9));
        for (int i = 0; i < 4000; i++) begin
            for (int k = 0; k < NC; k++) begin
                if ($urandom_range(0, 49) == 0) set_iv(k, $urandom_range(0, 9));
                unit_sent[k] = ($urandom_range(0, 99) < 20 + 20 * k);
            end
            if ($urandom_range(0, 99) == 0) limit_thresh = CW'($urandom_range(0, 255));
            cycle("R2,R5,R7,R8,R9");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule